// File: doc/BRIEF.md
# Page Write Staging Buffer

This block holds the data bytes of one write transaction before they reach memory. When a transaction opens, it latches the word address. The upper bits of that address fix the page. The low four bits give the first slot inside the 16-byte page. Each data byte that the bus receive path delivers in full lands in the current slot. The slot index then advances and wraps inside the page, so a long burst overwrites the slots it already filled. A per-slot valid mask records which slots hold data.

On a commit request with the commit enable high, the block walks the valid slots and writes each one to memory, one per cycle, through a byte-wide write port. It then raises a one-cycle done pulse. A byte that the receive path did not finish is never presented to this block, so such a byte leaves no trace. A commit with no complete byte writes nothing. An abort discards the staged contents, and it also stops a walk that is already running.

Top module: `pgw_stage`

## Requirements
- R1: After reset, `mem_we_o`, `busy_o` and `done_o` are 0 and the valid mask is empty.
- R2: Every memory write carries, in bits [7:4] of `mem_addr_o`, the page taken from bits [7:4] of the most recently accepted `open_addr_i`.
- R3: The first byte after an open goes to slot `open_addr_i[3:0]`. Each later byte goes to the next slot modulo 16, and `mem_addr_o[3:0]` carries that slot.
- R4: When more than 16 bytes arrive, each later byte replaces the earlier content of its wrapped slot, and only the last value is written.
- R5: A commit writes exactly the slots that received a byte since the last open, so min(n,16) writes for n bytes. No other write occurs.
- R6: A commit with an empty mask (no complete byte) makes no write and raises `done_o` in the next cycle.
- R7: Writes start in the cycle after the commit is accepted, one per cycle on consecutive cycles, in ascending slot order.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last write, and `busy_o` is low while it is high.
- R9: While `busy_o` is high, `byte_vld_i` and `open_i` are ignored. No byte offered during a walk is written by any later commit.
- R10: `abort_i` clears the valid mask, so a later commit writes nothing. During a walk, `abort_i` stops further writes from the next cycle on and suppresses `done_o`.
- R11: A commit with `commit_en_i` low discards the mask and causes no write and no `done_o`.
- R12: An open clears the valid mask. Bytes staged before a second open are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_i | input | 1 | Start of a write transaction; latches the address |
| open_addr_i | input | 8 | Starting word address |
| byte_vld_i | input | 1 | One fully received data byte is present |
| byte_i | input | 8 | The data byte |
| commit_i | input | 1 | Stop seen; request to commit staged bytes |
| commit_en_i | input | 1 | Writing allowed for this commit |
| abort_i | input | 1 | Discard staged bytes and stop any walk |
| busy_o | output | 1 | Commit walk in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 8 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| done_o | output | 1 | One-cycle pulse after the commit completes |

## Verification
The assertions take for granted that control inputs are single-cycle pulses. When several control inputs arrive in the same cycle, they assume the fixed priority abort, commit, open, byte. They also assume a commit is only issued while idle, since one raised during a walk is dropped. The stimulus therefore drives one control pulse per cycle, except where a case deliberately offers bytes and opens during a walk. The sweep varies the starting slot, the page and the byte count across both sides of the 16-byte boundary. Expected writes come from an arithmetic model of the slot wrap.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // Decoded request for one cycle, after priority resolution.
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_OPEN   = 3'd1,
    CMD_BYTE   = 3'd2,
    CMD_COMMIT = 3'd3,
    CMD_DROP   = 3'd4,
    CMD_ABORT  = 3'd5
  } pgw_cmd_e;
endpackage

// File: rtl/pgw_cursor.sv
module pgw_cursor #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  localparam int BASE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [BASE_W-1:0] base_o,
  output logic [IDX_W-1:0]  idx_o
);
  // Slot advance; the carry out of the slot field is dropped so it wraps in-page.
  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] s);
    return s + IDX_W'(1);
  endfunction

  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i[ADDR_W-1:IDX_W];
      idx_q  <= addr_i[IDX_W-1:0];
    end else if (step_i) begin
      idx_q  <= next_slot(idx_q);
    end
  end

  assign base_o = base_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DEPTH-1:0]  valid_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) valid_q[g] <= 1'b0;
      else if (hit)        valid_q[g] <= 1'b1;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign valid_o   = valid_q;

  // R9
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (valid_q == '0))
    else $error("staging mask filled during a commit walk");
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DEPTH-1:0] snap_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  // Lowest set bit of a mask; 0 when the mask is empty.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [DEPTH-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [DEPTH-1:0] pend_q;
  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] cur_idx;
  logic [DEPTH-1:0] pend_nxt;
  logic             last_write;

  assign cur_idx    = lowest_set(pend_q);
  assign pend_nxt   = pend_q & ~(DEPTH'(1) << cur_idx);
  assign last_write = busy_q && (pend_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        pend_q <= '0;
        busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        if (snap_i == '0) begin
          done_q <= 1'b1;
        end else begin
          pend_q <= snap_i;
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        pend_q <= pend_nxt;
        if (last_write) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign idx_o  = cur_idx;
  assign done_o = done_q;

  // R7
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> (!we_o || (idx_o > $past(idx_o))))
    else $error("commit writes out of ascending order");

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o)
    else $error("done raised while still busy");

  // R6
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !abort_i && (snap_i == '0)) |=> (done_o && !we_o))
    else $error("empty commit misbehaved");

  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!we_o && !done_o))
    else $error("write or done after abort");
endmodule

// File: rtl/pgw_stage.sv
module pgw_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BASE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] open_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              commit_en_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o
);
  import pgw_pkg::*;

  pgw_cmd_e          cmd;
  logic              busy;
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  wr_slot;
  logic [IDX_W-1:0]  walk_slot;
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] rd_data;
  logic              walk_we;

  // Named events for the checks: one decoded request per cycle.
  logic ev_open, ev_byte, ev_commit, ev_drop, ev_abort, ev_clear;

  always_comb begin
    cmd = CMD_NONE;
    if (abort_i)                 cmd = CMD_ABORT;
    else if (busy)               cmd = CMD_NONE;
    else if (commit_i)           cmd = commit_en_i ? CMD_COMMIT : CMD_DROP;
    else if (open_i)             cmd = CMD_OPEN;
    else if (byte_vld_i)         cmd = CMD_BYTE;
  end

  assign ev_open   = (cmd == CMD_OPEN);
  assign ev_byte   = (cmd == CMD_BYTE);
  assign ev_commit = (cmd == CMD_COMMIT);
  assign ev_drop   = (cmd == CMD_DROP);
  assign ev_abort  = (cmd == CMD_ABORT);
  assign ev_clear  = ev_open | ev_commit | ev_drop | ev_abort;

  pgw_cursor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ev_open),
    .addr_i (open_addr_i),
    .step_i (ev_byte),
    .base_o (base),
    .idx_o  (wr_slot)
  );

  pgw_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ev_byte),
    .wr_idx_i  (wr_slot),
    .wr_data_i (byte_i),
    .clr_i     (ev_clear),
    .busy_i    (busy),
    .rd_idx_i  (walk_slot),
    .rd_data_o (rd_data),
    .valid_o   (valid)
  );

  pgw_walker #(.DEPTH(DEPTH)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ev_commit),
    .snap_i  (valid),
    .abort_i (ev_abort),
    .busy_o  (busy),
    .we_o    (walk_we),
    .idx_o   (walk_slot),
    .done_o  (done_o)
  );

  assign busy_o      = busy;
  assign mem_we_o    = walk_we;
  assign mem_addr_o  = {base, walk_slot};
  assign mem_wdata_o = rd_data;

  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_addr_o[ADDR_W-1:IDX_W]))
    else $error("page changed during a commit walk");

  // R11
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (!mem_we_o && !done_o))
    else $error("disabled commit produced activity");
endmodule

// File: tb/pgw_stage_tb.sv
`timescale 1ns/100ps
module pgw_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       open_i = 1'b0;
  logic [7:0] open_addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       commit_i = 1'b0;
  logic       commit_en_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       busy_o, mem_we_o, done_o;
  logic [7:0] mem_addr_o, mem_wdata_o;

  always #2.5 clk = ~clk;

  pgw_stage u_dut (
    .clk(clk), .rst_n(rst_n), .open_i(open_i), .open_addr_i(open_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i),
    .commit_en_i(commit_en_i), .abort_i(abort_i), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .done_o(done_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // Recorded bus activity.
  logic [7:0] rec_addr [32];
  logic [7:0] rec_data [32];
  int         rec_cyc  [32];
  int         rec_n = 0;
  int         done_n = 0;
  int         done_cyc = 0;

  // Bench-side model of the staged page.
  bit         m_vld [16];
  logic [7:0] m_val [16];
  logic [3:0] m_base = '0;
  logic [3:0] m_ptr = '0;
  bit         s_vld [16];
  logic [7:0] s_val [16];
  logic [3:0] s_base = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_we_o && rec_n < 32) begin
      rec_addr[rec_n] = mem_addr_o;
      rec_data[rec_n] = mem_wdata_o;
      rec_cyc[rec_n]  = cyc;
      rec_n = rec_n + 1;
    end
    if (done_o) begin
      done_n = done_n + 1;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_rec();
    rec_n = 0;
    done_n = 0;
    done_cyc = 0;
  endtask

  function automatic logic [7:0] dat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic drv_open(input logic [3:0] b, input logic [3:0] s);
    open_i = 1'b1;
    open_addr_i = {b, s};
    tick();
    open_i = 1'b0;
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    m_base = b;
    m_ptr = s;
  endtask

  task automatic drv_byte(input logic [7:0] d);
    byte_vld_i = 1'b1;
    byte_i = d;
    tick();
    byte_vld_i = 1'b0;
    m_vld[m_ptr] = 1'b1;
    m_val[m_ptr] = d;
    m_ptr = m_ptr + 4'd1;
  endtask

  task automatic drv_commit(input bit en, output int c);
    c = cyc;
    commit_i = 1'b1;
    commit_en_i = en;
    tick();
    commit_i = 1'b0;
    commit_en_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      s_vld[i] = en ? m_vld[i] : 1'b0;
      s_val[i] = m_val[i];
      m_vld[i] = 1'b0;
    end
    s_base = m_base;
  endtask

  task automatic drv_abort();
    abort_i = 1'b1;
    tick();
    abort_i = 1'b0;
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
  endtask

  // Compare recorded writes with the snapshot taken at commit.
  task automatic check_walk(input int c, input bit expect_done);
    int j;
    int n_exp;
    repeat (40) tick();
    n_exp = 0;
    for (int i = 0; i < 16; i++) if (s_vld[i]) n_exp++;
    chk(rec_n == n_exp, "R5 write count", rec_n, n_exp);
    if (n_exp == 0 && expect_done)
      chk(rec_n == 0 && done_cyc == c + 1, "R6 empty commit done timing", done_cyc, c + 1);
    j = 0;
    for (int i = 0; i < 16; i++) begin
      if (s_vld[i] && j < rec_n) begin
        chk(rec_addr[j][7:4] == s_base, "R2 page bits", int'(rec_addr[j][7:4]), int'(s_base));
        chk(rec_addr[j][3:0] == 4'(i), "R3 slot order", int'(rec_addr[j][3:0]), i);
        chk(rec_data[j] == s_val[i], "R4 slot data", int'(rec_data[j]), int'(s_val[i]));
        chk(rec_cyc[j] == c + 1 + j, "R7 write cycle", rec_cyc[j], c + 1 + j);
        j++;
      end
    end
    if (expect_done) begin
      chk(done_n == 1, "R8 done pulse count", done_n, 1);
      chk(done_cyc == c + 1 + n_exp, "R8 done cycle", done_cyc, c + 1 + n_exp);
    end else begin
      chk(done_n == 0, "R11 no done", done_n, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    int nlist [6] = '{0, 1, 5, 15, 16, 19};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_we_o == 1'b0, "R1 reset we", int'(mem_we_o), 0);
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    tick();
    // R1: empty mask right after reset
    clear_rec();
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    drv_commit(1'b1, c);
    check_walk(c, 1'b1);

    // Sweep over start slot, page and byte count (R2 R3 R4 R5 R6 R7 R8).
    for (int s = 0; s < 16; s++) begin
      for (int ni = 0; ni < 6; ni++) begin
        clear_rec();
        drv_open(4'((s * 7 + ni) % 16), 4'(s));
        for (int k = 0; k < nlist[ni]; k++) begin
          drv_byte(dat(s * 16 + ni, k));
          if (k % 3 == 2) tick();
        end
        drv_commit(1'b1, c);
        check_walk(c, 1'b1);
      end
    end

    // R9: bytes and opens offered during a walk are refused.
    clear_rec();
    drv_open(4'd5, 4'd10);
    for (int k = 0; k < 16; k++) drv_byte(dat(99, k));
    drv_commit(1'b1, c);
    open_i = 1'b1;
    open_addr_i = 8'h00;
    byte_vld_i = 1'b1;
    byte_i = 8'hA5;
    repeat (5) tick();
    open_i = 1'b0;
    byte_vld_i = 1'b0;
    check_walk(c, 1'b1);
    clear_rec();
    drv_commit(1'b1, c);
    check_walk(c, 1'b1);
    chk(rec_n == 0, "R9 refused bytes unwritten", rec_n, 0);

    // R10: abort before commit.
    clear_rec();
    drv_open(4'd3, 4'd2);
    for (int k = 0; k < 4; k++) drv_byte(dat(7, k));
    drv_abort();
    drv_commit(1'b1, c);
    check_walk(c, 1'b1);
    chk(rec_n == 0, "R10 abort discards", rec_n, 0);

    // R10: abort in the middle of a walk.
    clear_rec();
    drv_open(4'd9, 4'd0);
    for (int k = 0; k < 16; k++) drv_byte(dat(8, k));
    drv_commit(1'b1, c);
    tick();
    drv_abort();
    repeat (30) tick();
    chk(rec_n == 2, "R10 writes before abort", rec_n, 2);
    chk(done_n == 0, "R10 no done after abort", done_n, 0);
    chk(rec_n > 1 && rec_addr[1] == 8'h91, "R10 second write addr", int'(rec_addr[1]), 8'h91);

    // R11: commit with enable low discards.
    clear_rec();
    drv_open(4'd6, 4'd14);
    for (int k = 0; k < 3; k++) drv_byte(dat(11, k));
    drv_commit(1'b0, c);
    check_walk(c, 1'b0);
    chk(rec_n == 0, "R11 disabled commit writes", rec_n, 0);
    clear_rec();
    drv_commit(1'b1, c);
    check_walk(c, 1'b1);
    chk(rec_n == 0, "R11 mask discarded", rec_n, 0);

    // R12: a second open clears bytes staged by the first.
    clear_rec();
    drv_open(4'd2, 4'd0);
    for (int k = 0; k < 3; k++) drv_byte(dat(12, k));
    drv_open(4'd12, 4'd8);
    for (int k = 0; k < 2; k++) drv_byte(dat(13, k));
    drv_commit(1'b1, c);
    check_walk(c, 1'b1);
    chk(rec_n == 2, "R12 only second transaction", rec_n, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule